// File: doc/BRIEF.md
# Up/Down Timer with Compare and Capture Channels

This block is a general-purpose 16-bit timer. A prescaler divides the clock into counter ticks. The counter then runs in one of two ways. In edge-aligned mode it ramps up from zero to a period value and wraps. In center-aligned mode it climbs to the period value and falls back to zero. Four channels watch the counter. A channel in compare mode drives a PWM output that stays high while the counter is below its compare value. A channel in capture mode instead copies the counter into its compare register when a chosen edge arrives on its input pin.

Software reaches the block through a word-addressed bus with a single write strobe. Read data is registered. Writes to the prescaler, the period and the compare values land in preload copies. The counter and the channels keep using the active copies until the next update event, so one period never mixes old and new settings. Status flags mark wrap events, compare matches and captures. Software clears a flag by writing 1 to its bit.

Top module: `gp_timer`

## Requirements
- R1: After reset the counter is 0, all PWM outputs are low, and the registers read as follows: the period register (word 3) reads 0xFFFF, the prescaler (word 2) reads 0, the control word (word 0) reads 0 and the status word (word 1) reads 0.
- R2: While the run bit (control bit 0) is 1, the counter moves one step every prescaler+1 clocks. While the run bit is 0, the counter holds its value.
- R3: In edge-aligned mode (control bit 1 = 0), the counter counts 0, 1, …, period and then returns to 0. The wrap sets the overflow flag (status bit 0) and is the update event.
- R4: In center-aligned mode (control bit 1 = 1), the counter rises from 0 to the period value, then falls to 0, and repeats. Reaching the period value sets the overflow flag (status bit 0). Reaching 0 on the way down sets the underflow flag (status bit 1), and only that return to 0 is the update event.
- R5: Each compare-mode PWM output is high while the counter is below the channel's active compare value, one clock after the counter value. In edge-aligned mode this gives a duty of compare/(period+1). A compare value of 0 keeps the output low, and a value above the period keeps it high.
- R6: Writes to the prescaler (word 2), the period (word 3) and compare value i (word 8+i) go to preload registers. Reads of these words return the active values. Preload values move to the active registers only at an update event.
- R7: Writing 1 to control bit 2 moves all preloads to the active registers at once and clears the counter and the prescaler. It sets neither the overflow flag nor the underflow flag.
- R8: The match flag of channel i (status bit 2+i) is set one clock after a tick moves the counter onto the active compare value. Writing a compare register or forcing an update never sets it.
- R9: The mode word (word 5) holds two bits per channel. Bit 2i enables capture, and bit 2i+1 selects the falling edge instead of the rising edge. The capture input passes through a two-flop synchroniser. A selected edge copies the counter into compare register i and sets the capture flag (status bit 6+i). The opposite edge does nothing. A capture-mode channel drives its PWM output low.
- R10: The status flags are cleared by writing 1 to their bits. A hardware set in the same clock wins over the clear.
- R11: Read data shows the word at the presented address one clock later. The counter reads at word 4, and unused words read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 4 | Asynchronous capture inputs, one per channel |
| pwm_out | output | 4 | Registered PWM outputs, one per channel |

## Verification
The bench measures duty over a full period for several compare values: a value inside the range, a value of zero, a value of exactly period+1, and a value above the period. An off-by-one comparison would show up as one cycle too many or too few per period. The bench writes new period and compare values in the middle of a period and reads them back before and after the wrap. A design without working preloads would show the new value too early. In center-aligned mode the bench checks the turning points (peak equal to the period value, floor equal to 0) and checks that both flags are set. It checks that capture uses the selected edge only and that the captured counter value has the expected synchroniser delay. It also checks that a forced update, or a compare write while the timer is stopped, sets no match flag.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  // word addresses of the register window
  localparam int A_CTRL = 0;
  localparam int A_FLAG = 1;
  localparam int A_PSC  = 2;
  localparam int A_ARR  = 3;
  localparam int A_CNT  = 4;
  localparam int A_MODE = 5;
  localparam int A_CCR0 = 8;

  // control word bit positions
  localparam int C_RUN    = 0;
  localparam int C_CENTER = 1;
  localparam int C_FORCE  = 2;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/gp_timer_base.sv
module gp_timer_base
  import gp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             center,
  input  logic             force_upd,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt,
  output logic             ticked,
  output logic             ovf_ev,
  output logic             unf_ev,
  output logic             upd_ev
);
  logic [PSC_W-1:0] pcnt_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  dir_e             dir_q, dir_nxt;
  logic             tick, at_top, at_floor, ticked_q;

  assign tick = run && (pcnt_q == psc);

  always_comb begin
    cnt_nxt  = cnt_q;
    dir_nxt  = dir_q;
    at_top   = 1'b0;
    at_floor = 1'b0;
    if (!center) begin
      dir_nxt = DIR_UP;
      if (cnt_q >= arr) begin
        at_top  = 1'b1;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end else if (dir_q == DIR_UP) begin
      if ((CNT_W+1)'(cnt_q) + 1'b1 >= (CNT_W+1)'(arr)) begin
        at_top  = 1'b1;
        cnt_nxt = arr;
        dir_nxt = DIR_DOWN;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q <= CNT_W'(1)) begin
        at_floor = 1'b1;
        cnt_nxt  = '0;
        dir_nxt  = DIR_UP;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  assign ovf_ev = tick && at_top && !force_upd;
  assign unf_ev = tick && at_floor && !force_upd;
  assign upd_ev = force_upd || (center ? unf_ev : ovf_ev);

  always_ff @(posedge clk) begin
    if (rst || force_upd) begin
      pcnt_q   <= '0;
      cnt_q    <= '0;
      dir_q    <= DIR_UP;
      ticked_q <= 1'b0;
    end else begin
      ticked_q <= tick;
      if (run) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
      if (tick) begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
    end
  end

  assign cnt    = cnt_q;
  assign ticked = ticked_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= arr);  // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !force_upd) |=> $stable(cnt_q));  // R2
  AST_CENTER_PEAK: assert property (@(posedge clk) disable iff (rst)
    (ovf_ev && center) |=> (cnt_q == $past(arr)));  // R4
endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan #(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ticked,
  input  logic             upd,
  input  logic             cap_mode,
  input  logic             cap_fall,
  input  logic             wr_pre,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cap_raw,
  output logic [CNT_W-1:0] ccr,
  output logic             pwm,
  output logic             match_p,
  output logic             cap_p
);
  logic [CNT_W-1:0] pre_q, act_q;
  logic [SYNC:0]    sync_q;
  logic             now_s, old_s, edge_hit;

  assign now_s    = sync_q[SYNC-1];
  assign old_s    = sync_q[SYNC];
  assign edge_hit = cap_fall ? (old_s && !now_s) : (now_s && !old_s);
  assign cap_p    = cap_mode && edge_hit;
  assign match_p  = ticked && !cap_mode && (cnt == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      act_q  <= '0;
      sync_q <= '0;
      pwm    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-1:0], cap_raw};
      pwm    <= !cap_mode && (cnt < act_q);
      if (wr_pre) pre_q <= wdata;
      if (cap_p) act_q <= cnt;
      else if (upd && !cap_mode) act_q <= pre_q;
    end
  end

  assign ccr = act_q;

  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    cap_p |=> (act_q == $past(cnt)));  // R9
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode && act_q == '0) |=> !pwm);  // R5
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int NCH   = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] pwm_out
);
  localparam int FLAG_W  = 2 + 2 * NCH;
  localparam int F_MATCH = 2;
  localparam int F_CAP   = 2 + NCH;

  logic             run, center, force_upd;
  logic [PSC_W-1:0] psc_pre, psc_act;
  logic [CNT_W-1:0] arr_pre, arr_act, cnt;
  logic [2*NCH-1:0] mode;
  logic [FLAG_W-1:0] flags, flag_set, flag_clr;
  logic             ticked, ovf_ev, unf_ev, upd;
  logic [NCH-1:0]   match_p, cap_p;
  logic [CNT_W-1:0] ccr_act [NCH];
  logic [DW-1:0]    rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  assign force_upd = bus_we && hit(bus_addr, A_CTRL) && bus_wdata[C_FORCE];

  gp_timer_base #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_base (
    .clk(clk), .rst(rst), .run(run), .center(center), .force_upd(force_upd),
    .psc(psc_act), .arr(arr_act), .cnt(cnt), .ticked(ticked),
    .ovf_ev(ovf_ev), .unf_ev(unf_ev), .upd_ev(upd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    gp_timer_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt), .ticked(ticked), .upd(upd),
      .cap_mode(mode[2*i]), .cap_fall(mode[2*i+1]),
      .wr_pre(bus_we && hit(bus_addr, A_CCR0 + i)),
      .wdata(bus_wdata[CNT_W-1:0]), .cap_raw(cap_in[i]),
      .ccr(ccr_act[i]), .pwm(pwm_out[i]),
      .match_p(match_p[i]), .cap_p(cap_p[i])
    );
  end

  assign flag_set = {cap_p, match_p, unf_ev, ovf_ev};
  assign flag_clr = (bus_we && hit(bus_addr, A_FLAG)) ? bus_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      center  <= 1'b0;
      psc_pre <= '0;
      psc_act <= '0;
      arr_pre <= '1;
      arr_act <= '1;
      mode    <= '0;
      flags   <= '0;
    end else begin
      if (bus_we && hit(bus_addr, A_CTRL)) begin
        run    <= bus_wdata[C_RUN];
        center <= bus_wdata[C_CENTER];
      end
      if (bus_we && hit(bus_addr, A_PSC))  psc_pre <= bus_wdata[PSC_W-1:0];
      if (bus_we && hit(bus_addr, A_ARR))  arr_pre <= bus_wdata[CNT_W-1:0];
      if (bus_we && hit(bus_addr, A_MODE)) mode    <= bus_wdata[2*NCH-1:0];
      if (upd) begin
        psc_act <= psc_pre;
        arr_act <= arr_pre;
      end
      flags <= (flags & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, A_CTRL)) rd_mux = DW'({center, run});
    if (hit(bus_addr, A_FLAG)) rd_mux = DW'(flags);
    if (hit(bus_addr, A_PSC))  rd_mux = DW'(psc_act);
    if (hit(bus_addr, A_ARR))  rd_mux = DW'(arr_act);
    if (hit(bus_addr, A_CNT))  rd_mux = DW'(cnt);
    if (hit(bus_addr, A_MODE)) rd_mux = DW'(mode);
    for (int i = 0; i < NCH; i++)
      if (hit(bus_addr, A_CCR0 + i)) rd_mux = DW'(ccr_act[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit(bus_addr, A_FLAG) && bus_wdata[0] && !ovf_ev) |=> !flags[0]);  // R10
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    force_upd |=> (cnt == '0));  // R7
  AST_FORCE_NO_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (force_upd && flags[1:0] == 2'b00 && !flag_clr[0] && !flag_clr[1]) |=> (flags[1:0] == 2'b00));  // R7
  AST_MATCH_FLAG_POS: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_MATCH]) |-> $past(ticked));  // R8
  AST_CAP_FLAG_POS: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_CAP]) |-> $past(mode[0]));  // R9
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gp_timer dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pcnt, m_cnt, m_dir, m_ticked, m_run, m_center;
  int m_psc_p, m_psc_a, m_arr_p, m_arr_a, m_mode, m_flags, m_rd;
  int m_ccr_p[4], m_ccr_a[4], m_s1[4], m_s2[4], m_s3[4], m_pwm[4];

  always @(posedge clk) begin : model
    int tick, top, flo, ncnt, ndir, frc, ovf_e, unf_e, upd, setv, clr, rd, cap, fall;
    int nccr[4], npwm[4], ev;
    if (rst) begin
      m_pcnt = 0; m_cnt = 0; m_dir = 0; m_ticked = 0; m_run = 0; m_center = 0;
      m_psc_p = 0; m_psc_a = 0; m_arr_p = 65535; m_arr_a = 65535; m_mode = 0;
      m_flags = 0; m_rd = 0;
      for (int i = 0; i < 4; i++) begin
        m_ccr_p[i] = 0; m_ccr_a[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_pwm[i] = 0;
      end
    end else begin
      tick = (m_run != 0 && m_pcnt == m_psc_a) ? 1 : 0;
      top = 0; flo = 0; ncnt = m_cnt; ndir = m_dir;
      if (m_center == 0) begin
        ndir = 0;
        if (m_cnt >= m_arr_a) begin top = 1; ncnt = 0; end else ncnt = m_cnt + 1;
      end else if (m_dir == 0) begin
        if (m_cnt + 1 >= m_arr_a) begin top = 1; ncnt = m_arr_a; ndir = 1; end else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt <= 1) begin flo = 1; ncnt = 0; ndir = 0; end else ncnt = m_cnt - 1;
      end
      frc = (bus_we && bus_addr == 0 && bus_wdata[2]) ? 1 : 0;
      ovf_e = (tick && top && !frc) ? 1 : 0;
      unf_e = (tick && flo && !frc) ? 1 : 0;
      upd = (frc || (m_center != 0 ? unf_e : ovf_e)) ? 1 : 0;
      case (bus_addr)
        0: rd = m_run | (m_center << 1);
        1: rd = m_flags;
        2: rd = m_psc_a;
        3: rd = m_arr_a;
        4: rd = m_cnt;
        5: rd = m_mode;
        8, 9, 10, 11: rd = m_ccr_a[bus_addr - 8];
        default: rd = 0;
      endcase
      setv = ovf_e | (unf_e << 1);
      for (int i = 0; i < 4; i++) begin
        cap = (m_mode >> (2 * i)) & 1;
        fall = (m_mode >> (2 * i + 1)) & 1;
        ev = (cap != 0) && (fall != 0 ? (m_s3[i] && !m_s2[i]) : (m_s2[i] && !m_s3[i]));
        npwm[i] = (cap == 0 && m_cnt < m_ccr_a[i]) ? 1 : 0;
        if (m_ticked != 0 && cap == 0 && m_cnt == m_ccr_a[i]) setv |= 1 << (2 + i);
        if (ev) setv |= 1 << (6 + i);
        nccr[i] = ev ? m_cnt : ((cap == 0 && upd != 0) ? m_ccr_p[i] : m_ccr_a[i]);
      end
      clr = (bus_we && bus_addr == 1) ? (bus_wdata & 32'h3FF) : 0;
      m_flags = (m_flags & ~clr) | setv;
      if (frc) begin
        m_pcnt = 0; m_cnt = 0; m_dir = 0; m_ticked = 0;
      end else begin
        m_ticked = tick;
        if (m_run != 0) m_pcnt = tick ? 0 : m_pcnt + 1;
        if (tick) begin m_cnt = ncnt; m_dir = ndir; end
      end
      if (upd) begin m_psc_a = m_psc_p; m_arr_a = m_arr_p; end
      for (int i = 0; i < 4; i++) begin
        m_ccr_a[i] = nccr[i];
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = cap_in[i];
        m_pwm[i] = npwm[i];
      end
      if (bus_we) begin
        case (bus_addr)
          0: begin m_run = bus_wdata[0]; m_center = bus_wdata[1]; end
          2: m_psc_p = bus_wdata & 32'hFFFF;
          3: m_arr_p = bus_wdata & 32'hFFFF;
          5: m_mode = bus_wdata & 32'hFF;
          8, 9, 10, 11: m_ccr_p[bus_addr - 8] = bus_wdata & 32'hFFFF;
          default: ;
        endcase
      end
      m_rd = rd;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 4; i++) chk("R5 pwm vs model", pwm_out[i], m_pwm[i]);
      chk("R11 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 4'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  int hi[4];
  task automatic duty(input int n);
    for (int i = 0; i < 4; i++) hi[i] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) hi[i] += pwm_out[i];
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int v, vmax, vmin, c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3, v); chk("R1 period reset", v, 65535);
    rd(2, v); chk("R1 prescaler reset", v, 0);
    rd(0, v); chk("R1 control reset", v, 0);
    rd(1, v); chk("R1 flags reset", v, 0);
    rd(4, v); chk("R1 counter reset", v, 0);
    chk("R1 pwm reset", pwm_out, 0);

    // R3/R5 edge-aligned duty incl. zero and above-period compare values
    wr(2, 0); wr(3, 9);
    wr(8, 3); wr(9, 0); wr(10, 12); wr(11, 10);
    wr(0, 5);
    repeat (3) @(negedge clk);
    duty(10);
    chk("R5 duty 3/10", hi[0], 3);
    chk("R5 compare zero low", hi[1], 0);
    chk("R5 compare above period high", hi[2], 10);
    chk("R5 compare period+1 high", hi[3], 10);

    // R6 preload: writes mid-period are not active until the wrap
    wr(0, 5);
    wr(3, 19); wr(8, 15);
    rd(3, v); chk("R6 period still old", v, 9);
    rd(8, v); chk("R6 compare still old", v, 3);
    repeat (20) @(negedge clk);
    rd(3, v); chk("R6 period after update", v, 19);
    rd(8, v); chk("R6 compare after update", v, 15);
    duty(20);
    chk("R6 duty with new period", hi[0], 15);

    // R2 prescaler divides ticks
    wr(2, 1); wr(0, 5);
    repeat (3) @(negedge clk);
    duty(40);
    chk("R2 duty prescaled ch0", hi[0], 30);
    chk("R2 duty prescaled ch3", hi[3], 20);

    // R3/R8 flags while running
    wr(1, 32'h3FF);
    repeat (50) @(negedge clk);
    rd(1, v); chk("R3 R8 overflow and match flags", v, 32'h3D);

    // R2 stop holds the counter
    wr(0, 0);
    rd(4, v);
    repeat (6) @(negedge clk);
    rd(4, c0); chk("R2 counter holds when stopped", c0, v);

    // R10 write-one-to-clear
    wr(1, 1);
    rd(1, v); chk("R10 clear only bit0", v, 32'h3C);
    wr(1, 32'h3FF);
    rd(1, v); chk("R10 clear all", v, 0);

    // R7/R8 forced update with compare 0 sets no flag and clears counter
    wr(8, 0); wr(0, 4);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R8 R7 no flag from write or force", v, 0);
    rd(4, v); chk("R7 counter cleared", v, 0);
    rd(8, v); chk("R7 compare transferred", v, 0);

    // R4 center-aligned
    wr(2, 0); wr(3, 8); wr(8, 4);
    wr(0, 7);
    wr(1, 32'h3FF);
    repeat (3) @(negedge clk);
    bus_addr = 4'd4;
    vmax = 0; vmin = 65535; c0 = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (int'(bus_rdata) > vmax) vmax = bus_rdata;
      if (int'(bus_rdata) < vmin) vmin = bus_rdata;
      c0 += pwm_out[0];
    end
    chk("R4 peak equals period", vmax, 8);
    chk("R4 floor zero", vmin, 0);
    chk("R4 R5 center duty", c0, 7);
    rd(1, v); chk("R4 overflow and underflow flags", v & 3, 3);

    // R9 capture
    wr(3, 1000);
    wr(5, 32'h34);
    wr(1, 32'h3FF);
    wr(0, 5);
    cap_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(9, v); chk("R9 captured value", v, 2);
    rd(1, v); chk("R9 capture flag ch1", (v >> 7) & 1, 1);
    chk("R9 capture channel pwm low", pwm_out[1], 0);
    wr(1, 32'h3FF);
    cap_in[2] = 1'b1;
    repeat (5) @(negedge clk);
    rd(1, v); chk("R9 rising ignored on falling channel", (v >> 8) & 1, 0);
    rd(10, v); chk("R9 ignored edge leaves register", v, 12);
    cap_in[2] = 1'b0;
    repeat (5) @(negedge clk);
    rd(1, v); chk("R9 falling edge captured", (v >> 8) & 1, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule